// File: doc/BRIEF.md
# Gateway Ingress Steering Filter

This block sits right after a packet parser at the ingress of a mobile gateway datapath. It makes one forwarding decision for each parsed packet. Each packet arrives as a single-cycle descriptor. The descriptor carries the parser's header-valid flags, the outer MAC and IPv4 addresses, and the packet length. The block returns a verdict with four parts:

- the direction: towards the network (uplink) or towards the user (downlink);
- whether the packet is discarded;
- whether its 36-byte tunnel header is to be stripped;
- the length left after that strip.

The checks run in a fixed order. The outer source MAC and the outer destination MAC are each looked up in their own table, and both must hit. The outer IPv4 header must be valid. A valid GTP header sends the packet uplink, and its absence sends it downlink. A shared address filter, keyed on the outer source IPv4 address, then permits or denies the packet. On the uplink, decapsulation happens only when the outer destination IPv4 address equals the gateway's own address.

The two MAC tables, the filter table and a settings word are loaded through a simple write port. The settings word holds the gateway address and the filter's default action. Every table entry carries a valid bit. Results leave in arrival order after a fixed two-cycle latency, and a new packet may be accepted every cycle.

Top module: `gw_steer_filter`

## Requirements
- R1: After reset, `out_valid` is low, every table entry is invalid, the gateway address is 0 and the filter default is deny, so any packet presented is dropped.
- R2: A packet whose outer source MAC matches no valid entry of the source table, or whose outer destination MAC matches no valid entry of the destination table, is dropped. A dropped packet always has `out_decap` = 0 and `out_len` equal to its input length.
- R3: A packet whose MAC checks pass but whose `in_ipv4_ok` is 0 is dropped.
- R4: `out_path` is 1 (uplink) when `in_gtp_ok` was 1 and 0 (downlink) otherwise. This holds for every result, including drops.
- R5: The filter is keyed on `in_src_ip`. When several valid entries match, the lowest-indexed one decides: a permit bit of 1 passes the packet and 0 drops it. When no entry matches, the default action decides.
- R6: An uplink packet that passes the earlier checks, whose `in_dst_ip` equals the gateway address and whose length is at least 36, leaves with `out_decap` = 1 and `out_len` = `in_len` − 36. A length of exactly 36 gives 0.
- R7: An uplink packet whose `in_dst_ip` differs from the gateway address is dropped.
- R8: An uplink packet shorter than 36 bytes that would otherwise be decapsulated is dropped.
- R9: A downlink packet that passes all checks leaves with `out_drop` = 0, `out_decap` = 0 and `out_len` = `in_len`.
- R10: Each packet presented with `in_valid` high produces exactly one result with `out_valid` high, two clock cycles later and in arrival order, including on back-to-back cycles. No result appears without a packet.
- R11: Table writes use `cfg_table` to pick the target:
  - 0 selects the source MAC table (key `cfg_key[47:0]`);
  - 1 selects the destination MAC table (key `cfg_key[47:0]`);
  - 2 selects the filter table (key `cfg_key[31:0]`, permit bit `cfg_permit`);
  - 3 selects settings (gateway address `cfg_key[31:0]`, default action `cfg_permit`, where 1 means permit; index and valid bit are ignored).

  For tables 0 to 2, `cfg_valid` sets the entry's valid bit, so writing 0 removes the entry. A write applies to packets presented in later cycles, not to a packet presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet descriptor present this cycle |
| in_ipv4_ok | input | 1 | Parser found a valid outer IPv4 header |
| in_gtp_ok | input | 1 | Parser found a valid GTP header |
| in_src_mac | input | 48 | Outer source MAC address |
| in_dst_mac | input | 48 | Outer destination MAC address |
| in_src_ip | input | 32 | Outer source IPv4 address |
| in_dst_ip | input | 32 | Outer destination IPv4 address |
| in_len | input | 16 | Packet length in bytes |
| cfg_we | input | 1 | Table write strobe |
| cfg_table | input | 2 | Write target: 0 src MAC, 1 dst MAC, 2 filter, 3 settings |
| cfg_index | input | 3 | Entry index within the target table |
| cfg_valid | input | 1 | Valid bit written to the entry |
| cfg_key | input | 48 | MAC key, or IPv4 address in bits 31:0 |
| cfg_permit | input | 1 | Filter entry action, or default action for settings |
| out_valid | output | 1 | Verdict present |
| out_path | output | 1 | 1 uplink, 0 downlink |
| out_drop | output | 1 | Packet is discarded |
| out_decap | output | 1 | Tunnel header to be removed |
| out_len | output | 16 | Length after any removal |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Filter priority.** Two filter entries hold the same address with opposite actions. A table that lets the highest index win, or ORs the actions, would pass or drop the wrong packets.
- **Length boundary.** Uplink lengths of 35, 36 and 100 probe the strip edge. An off-by-one comparison would either drop a 36-byte packet or wrap a 35-byte length to a large value.
- **Write timing.** A settings write lands in the same cycle as a packet, which must still see the old default. Filter entries are also removed by clearing their valid bit. A design that bypasses the write into the lookup, or ignores the valid bit, would change those verdicts.
- **Pipeline order.** Back-to-back bursts with gaps would expose dropped, duplicated or reordered results.

// File: rtl/gw_steer_pkg.sv
package gw_steer_pkg;

    localparam int MAC_W     = 48;
    localparam int IP_W      = 32;
    localparam int LEN_W     = 16;
    localparam int TUN_BYTES = 36;

    typedef enum logic [1:0] {
        SEL_SRC_MAC  = 2'd0,
        SEL_DST_MAC  = 2'd1,
        SEL_FILTER   = 2'd2,
        SEL_SETTINGS = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Lookup outcomes captured in the first pipeline stage
    typedef struct packed {
        logic              vld;
        logic              mac_ok;
        logic              ip_ok;
        dir_e              dir;
        logic              fw_ok;
        logic              gw_hit;
        logic [LEN_W-1:0]  len;
    } stage_t;

    typedef struct packed {
        logic              vld;
        dir_e              dir;
        logic              drop;
        logic              decap;
        logic [LEN_W-1:0]  len;
    } verdict_t;

    function automatic logic is_runt(input logic [LEN_W-1:0] l);
        return l < LEN_W'(TUN_BYTES);
    endfunction

    function automatic logic [LEN_W-1:0] strip_len(input logic [LEN_W-1:0] l);
        return l - LEN_W'(TUN_BYTES);
    endfunction

endpackage

// File: rtl/gw_key_table.sv
module gw_key_table #(
    parameter int KEY_W = 48,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] look_key,
    output logic             hit
);

    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    vld_q[i] <= wr_valid;
                    key_q[i] <= wr_key;
                end
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (key_q[g] == look_key);
    end

    assign hit = |match;

endmodule

// File: rtl/gw_fw_table.sv
module gw_fw_table #(
    parameter int KEY_W = 32,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             wr_permit,
    input  logic [KEY_W-1:0] look_key,
    output logic             hit,
    output logic             permit
);

    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] act_q;
    logic [DEPTH-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            act_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    vld_q[i] <= wr_valid;
                    key_q[i] <= wr_key;
                    act_q[i] <= wr_permit;
                end
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (key_q[g] == look_key);
    end

    // Lowest matching index takes priority: scan downward, last write wins
    always_comb begin
        permit = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) permit = act_q[i];
        end
    end

    assign hit = |match;

endmodule

// File: rtl/gw_verdict.sv
module gw_verdict
    import gw_steer_pkg::*;
(
    input  stage_t   st,
    output verdict_t vd
);

    logic common_ok;
    logic up_ok;

    always_comb begin
        common_ok = st.mac_ok && st.ip_ok && st.fw_ok;
        up_ok     = common_ok && st.gw_hit && !is_runt(st.len);

        vd.vld   = st.vld;
        vd.dir   = st.dir;
        vd.decap = 1'b0;
        vd.len   = st.len;
        if (st.dir == DIR_UP) begin
            vd.drop = !up_ok;
            if (up_ok) begin
                vd.decap = 1'b1;
                vd.len   = strip_len(st.len);
            end
        end else begin
            vd.drop = !common_ok;
        end
    end

endmodule

// File: rtl/gw_steer_filter.sv
module gw_steer_filter
    import gw_steer_pkg::*;
#(
    parameter int MAC_DEPTH = 8,
    parameter int FW_DEPTH  = 8,
    localparam int CFG_IDX_W = $clog2((MAC_DEPTH > FW_DEPTH) ? MAC_DEPTH : FW_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_ipv4_ok,
    input  logic                 in_gtp_ok,
    input  logic [MAC_W-1:0]     in_src_mac,
    input  logic [MAC_W-1:0]     in_dst_mac,
    input  logic [IP_W-1:0]      in_src_ip,
    input  logic [IP_W-1:0]      in_dst_ip,
    input  logic [LEN_W-1:0]     in_len,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_table,
    input  logic [CFG_IDX_W-1:0] cfg_index,
    input  logic                 cfg_valid,
    input  logic [MAC_W-1:0]     cfg_key,
    input  logic                 cfg_permit,
    output logic                 out_valid,
    output logic                 out_path,
    output logic                 out_drop,
    output logic                 out_decap,
    output logic [LEN_W-1:0]     out_len
);

    localparam int MAC_IDX_W = $clog2(MAC_DEPTH);
    localparam int FW_IDX_W  = $clog2(FW_DEPTH);

    cfg_sel_e        sel;
    logic            we_smac, we_dmac, we_fw, we_set;
    logic            smac_hit, dmac_hit, fw_hit, fw_permit;
    logic [IP_W-1:0] gw_addr_q;
    logic            dflt_permit_q;
    stage_t          s1_q;
    verdict_t        vd, out_q;

    assign sel     = cfg_sel_e'(cfg_table);
    assign we_smac = cfg_we && (sel == SEL_SRC_MAC);
    assign we_dmac = cfg_we && (sel == SEL_DST_MAC);
    assign we_fw   = cfg_we && (sel == SEL_FILTER);
    assign we_set  = cfg_we && (sel == SEL_SETTINGS);

    gw_key_table #(.KEY_W(MAC_W), .DEPTH(MAC_DEPTH)) u_src_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (we_smac),
        .wr_idx   (cfg_index[MAC_IDX_W-1:0]),
        .wr_valid (cfg_valid),
        .wr_key   (cfg_key),
        .look_key (in_src_mac),
        .hit      (smac_hit)
    );

    gw_key_table #(.KEY_W(MAC_W), .DEPTH(MAC_DEPTH)) u_dst_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (we_dmac),
        .wr_idx   (cfg_index[MAC_IDX_W-1:0]),
        .wr_valid (cfg_valid),
        .wr_key   (cfg_key),
        .look_key (in_dst_mac),
        .hit      (dmac_hit)
    );

    gw_fw_table #(.KEY_W(IP_W), .DEPTH(FW_DEPTH)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (we_fw),
        .wr_idx    (cfg_index[FW_IDX_W-1:0]),
        .wr_valid  (cfg_valid),
        .wr_key    (cfg_key[IP_W-1:0]),
        .wr_permit (cfg_permit),
        .look_key  (in_src_ip),
        .hit       (fw_hit),
        .permit    (fw_permit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gw_addr_q     <= '0;
            dflt_permit_q <= 1'b0;
        end else if (we_set) begin
            gw_addr_q     <= cfg_key[IP_W-1:0];
            dflt_permit_q <= cfg_permit;
        end
    end

    // Stage 1: capture every lookup against the table state of this cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld    <= in_valid;
            s1_q.mac_ok <= smac_hit && dmac_hit;
            s1_q.ip_ok  <= in_ipv4_ok;
            s1_q.dir    <= in_gtp_ok ? DIR_UP : DIR_DOWN;
            s1_q.fw_ok  <= fw_hit ? fw_permit : dflt_permit_q;
            s1_q.gw_hit <= (in_dst_ip == gw_addr_q);
            s1_q.len    <= in_len;
        end
    end

    gw_verdict u_verdict (
        .st (s1_q),
        .vd (vd)
    );

    // Stage 2: registered verdict
    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= vd;
    end

    assign out_valid = out_q.vld;
    assign out_path  = out_q.dir;
    assign out_drop  = out_q.drop;
    assign out_decap = out_q.decap;
    assign out_len   = out_q.len;

endmodule

// File: rtl/gw_steer_filter_chk.sv
module gw_steer_filter_chk
    import gw_steer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ipv4_ok,
    input logic             in_gtp_ok,
    input logic [LEN_W-1:0] in_len,
    input logic             out_valid,
    input logic             out_path,
    input logic             out_drop,
    input logic             out_decap,
    input logic [LEN_W-1:0] out_len
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid); // R10

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid); // R10

    AST_PATH_FOLLOWS_GTP: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 (out_path == $past(in_gtp_ok, 2))); // R4

    AST_BAD_IPV4_DROPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ipv4_ok) |-> ##2 out_drop); // R3

    AST_DROP_KEEPS_LEN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_drop) |-> (!out_decap && out_len == $past(in_len, 2))); // R2

    AST_DECAP_STRIPS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_decap) |->
            (out_path && out_len == $past(in_len, 2) - LEN_W'(TUN_BYTES))); // R6

    AST_DOWN_NO_DECAP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_path) |-> !out_decap); // R9

endmodule

bind gw_steer_filter gw_steer_filter_chk u_chk (.*);

// File: tb/gw_steer_filter_test.sv
`timescale 1ns/1ps
module gw_steer_filter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ipv4_ok, in_gtp_ok;
    logic [47:0] in_src_mac, in_dst_mac;
    logic [31:0] in_src_ip, in_dst_ip;
    logic [15:0] in_len;
    logic        cfg_we;
    logic [1:0]  cfg_table;
    logic [2:0]  cfg_index;
    logic        cfg_valid;
    logic [47:0] cfg_key;
    logic        cfg_permit;
    logic        out_valid, out_path, out_drop, out_decap;
    logic [15:0] out_len;

    gw_steer_filter uut (.*);

    always #2.5 clk = ~clk;

    localparam logic [47:0] MAC_A = 48'h0200_0000_000A;
    localparam logic [47:0] MAC_B = 48'h0200_0000_000B;
    localparam logic [47:0] MAC_C = 48'h0200_0000_000C;
    localparam logic [31:0] IP_X  = 32'h0A00_0001;
    localparam logic [31:0] IP_Y  = 32'h0A00_0002;
    localparam logic [31:0] IP_Z  = 32'h0A00_0003;
    localparam logic [31:0] IP_G  = 32'hC0A8_0001;

    // Behavioural model state
    logic [47:0] m_smac [8];
    logic [47:0] m_dmac [8];
    logic [31:0] m_fw   [8];
    logic [7:0]  m_smac_v, m_dmac_v, m_fw_v, m_fw_act;
    logic [31:0] m_gw;
    logic        m_dflt;

    // Staged stimulus for the next cycle
    logic        st_rst = 1'b1, st_v = 1'b0, st_ip = 1'b0, st_gtp = 1'b0;
    logic [47:0] st_smac = '0, st_dmac = '0;
    logic [31:0] st_sip = '0, st_dip = '0;
    logic [15:0] st_len = '0;
    logic        st_we = 1'b0, st_cv = 1'b0, st_cp = 1'b0;
    logic [1:0]  st_tbl = '0;
    logic [2:0]  st_idx = '0;
    logic [47:0] st_key = '0;
    string       st_tag = "";

    // Expected results: current cycle and two pipeline slots
    logic        c_v, c_p, c_d, c_x; logic [15:0] c_l; string c_tag;
    logic        p1_v, p1_p, p1_d, p1_x; logic [15:0] p1_l; string p1_tag;
    logic        p2_v, p2_p, p2_d, p2_x; logic [15:0] p2_l; string p2_tag;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_smac_v <= '0; m_dmac_v <= '0; m_fw_v <= '0; m_fw_act <= '0;
            m_gw <= '0; m_dflt <= 1'b0;
            p1_v <= 1'b0; p2_v <= 1'b0;
            p1_tag <= "R1"; p2_tag <= "R1";
        end else begin
            p2_v <= p1_v; p2_p <= p1_p; p2_d <= p1_d; p2_x <= p1_x; p2_l <= p1_l; p2_tag <= p1_tag;
            p1_v <= c_v;  p1_p <= c_p;  p1_d <= c_d;  p1_x <= c_x;  p1_l <= c_l;  p1_tag <= c_tag;
            if (cfg_we) begin
                case (cfg_table)
                    2'd0: begin m_smac[cfg_index] <= cfg_key; m_smac_v[cfg_index] <= cfg_valid; end
                    2'd1: begin m_dmac[cfg_index] <= cfg_key; m_dmac_v[cfg_index] <= cfg_valid; end
                    2'd2: begin m_fw[cfg_index] <= cfg_key[31:0]; m_fw_v[cfg_index] <= cfg_valid;
                                m_fw_act[cfg_index] <= cfg_permit; end
                    default: begin m_gw <= cfg_key[31:0]; m_dflt <= cfg_permit; end
                endcase
            end
        end
    end

    task automatic compare();
        vectors++;
        if (out_valid !== p2_v ||
            (p2_v && (out_path !== p2_p || out_drop !== p2_d || out_decap !== p2_x || out_len !== p2_l))) begin
            miscompares++;
            $display("FAIL %s: got v=%0d path=%0d drop=%0d decap=%0d len=%0d exp v=%0d path=%0d drop=%0d decap=%0d len=%0d",
                     p2_tag, out_valid, out_path, out_drop, out_decap, out_len,
                     p2_v, p2_p, p2_d, p2_x, p2_l);
        end
    endtask

    task automatic predict();
        bit s_ok = 0, d_ok = 0, f_hit = 0, f_ok;
        for (int i = 0; i < 8; i++) begin
            if (m_smac_v[i] && m_smac[i] == st_smac) s_ok = 1;
            if (m_dmac_v[i] && m_dmac[i] == st_dmac) d_ok = 1;
        end
        f_ok = m_dflt;
        for (int i = 0; i < 8; i++) begin
            if (!f_hit && m_fw_v[i] && m_fw[i] == st_sip) begin f_hit = 1; f_ok = m_fw_act[i]; end
        end
        c_v = st_v; c_p = st_gtp; c_d = 1'b1; c_x = 1'b0; c_l = st_len;
        if (!st_v)                c_tag = st_rst ? "R1" : "R10";
        else if (!(s_ok && d_ok)) c_tag = "R2";
        else if (!st_ip)          c_tag = "R3";
        else if (!f_ok)           c_tag = "R5";
        else if (st_gtp) begin
            if (st_dip != m_gw)     c_tag = "R7";
            else if (st_len < 36)   c_tag = "R8";
            else begin c_tag = "R6"; c_d = 1'b0; c_x = 1'b1; c_l = st_len - 16'd36; end
        end else begin
            c_tag = "R9"; c_d = 1'b0;
        end
        if (st_tag != "") c_tag = st_tag;
    endtask

    task automatic cycle();
        @(negedge clk);
        compare();
        rst = st_rst; in_valid = st_v; in_ipv4_ok = st_ip; in_gtp_ok = st_gtp;
        in_src_mac = st_smac; in_dst_mac = st_dmac; in_src_ip = st_sip; in_dst_ip = st_dip;
        in_len = st_len; cfg_we = st_we; cfg_table = st_tbl; cfg_index = st_idx;
        cfg_valid = st_cv; cfg_key = st_key; cfg_permit = st_cp;
        predict();
        st_v = 1'b0; st_we = 1'b0; st_tag = "";
    endtask

    task automatic set_pkt(input bit gtp, input bit ip, input logic [47:0] sm, input logic [47:0] dm,
                           input logic [31:0] sip, input logic [31:0] dip, input logic [15:0] len);
        st_v = 1'b1; st_gtp = gtp; st_ip = ip; st_smac = sm; st_dmac = dm;
        st_sip = sip; st_dip = dip; st_len = len;
    endtask

    task automatic set_cfg(input logic [1:0] tbl, input logic [2:0] idx, input bit vld,
                           input logic [47:0] key, input bit prm);
        st_we = 1'b1; st_tbl = tbl; st_idx = idx; st_cv = vld; st_key = key; st_cp = prm;
    endtask

    task automatic pkt(input bit gtp, input bit ip, input logic [47:0] sm, input logic [47:0] dm,
                       input logic [31:0] sip, input logic [31:0] dip, input logic [15:0] len);
        set_pkt(gtp, ip, sm, dm, sip, dip, len);
        cycle();
    endtask

    task automatic cfg(input logic [1:0] tbl, input logic [2:0] idx, input bit vld,
                       input logic [47:0] key, input bit prm);
        set_cfg(tbl, idx, vld, key, prm);
        cycle();
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_ipv4_ok = 1'b0; in_gtp_ok = 1'b0;
        in_src_mac = '0; in_dst_mac = '0; in_src_ip = '0; in_dst_ip = '0; in_len = '0;
        cfg_we = 1'b0; cfg_table = '0; cfg_index = '0; cfg_valid = 1'b0; cfg_key = '0; cfg_permit = 1'b0;
        c_v = 0; c_p = 0; c_d = 0; c_x = 0; c_l = 0; c_tag = "R1";
        @(posedge clk);
        // R1: held in reset, then empty tables drop everything
        repeat (3) cycle();
        st_rst = 1'b0;
        cycle();
        st_tag = "R1"; pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_X, IP_G, 16'd80);
        st_tag = "R1"; pkt(1'b1, 1'b1, MAC_A, MAC_B, IP_X, IP_G, 16'd80);

        // R11: load tables
        cfg(2'd0, 3'd0, 1'b1, MAC_A, 1'b0);
        cfg(2'd1, 3'd3, 1'b1, MAC_B, 1'b0);
        cfg(2'd2, 3'd2, 1'b1, {16'h0, IP_X}, 1'b1);
        cfg(2'd2, 3'd5, 1'b1, {16'h0, IP_X}, 1'b0);
        cfg(2'd2, 3'd1, 1'b1, {16'h0, IP_Y}, 1'b0);
        cfg(2'd3, 3'd0, 1'b0, {16'h0, IP_G}, 1'b0);

        pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_X, IP_Z, 16'd64);   // R9 pass, R5 lowest index permits
        pkt(1'b1, 1'b1, MAC_A, MAC_B, IP_X, IP_G, 16'd100);  // R6
        pkt(1'b1, 1'b1, MAC_A, MAC_B, IP_X, IP_G, 16'd36);   // R6 boundary -> 0
        pkt(1'b1, 1'b1, MAC_A, MAC_B, IP_X, IP_G, 16'd35);   // R8
        pkt(1'b1, 1'b1, MAC_A, MAC_B, IP_X, IP_Y, 16'd120);  // R7
        pkt(1'b0, 1'b1, MAC_C, MAC_B, IP_X, IP_Z, 16'd70);   // R2 src miss
        pkt(1'b1, 1'b1, MAC_A, MAC_C, IP_X, IP_G, 16'd70);   // R2 dst miss
        pkt(1'b1, 1'b0, MAC_A, MAC_B, IP_X, IP_G, 16'd90);   // R3
        pkt(1'b0, 1'b0, MAC_A, MAC_B, IP_X, IP_G, 16'd90);   // R3 downlink, R4
        pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_Y, IP_Z, 16'd66);   // R5 deny entry
        pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_Z, IP_X, 16'd66);   // R5 default deny

        // R11: settings write in the same cycle as a packet; packet sees old default
        set_cfg(2'd3, 3'd0, 1'b0, {16'h0, IP_G}, 1'b1);
        st_tag = "R11"; set_pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_Z, IP_X, 16'd66);
        cycle();
        st_tag = "R11"; pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_Z, IP_X, 16'd66);

        // R11: remove the permit entry at index 2; index 5 now denies
        cfg(2'd2, 3'd2, 1'b0, {16'h0, IP_X}, 1'b1);
        st_tag = "R11"; pkt(1'b1, 1'b1, MAC_A, MAC_B, IP_X, IP_G, 16'd100);
        cfg(2'd2, 3'd4, 1'b1, {16'h0, IP_Y}, 1'b1);
        st_tag = "R5"; pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_Y, IP_G, 16'd100);

        // R10: back-to-back burst with gaps and mixed outcomes
        for (int k = 0; k < 40; k++) begin
            logic [31:0] s;
            s = (k % 3 == 0) ? IP_Z : ((k % 3 == 1) ? IP_Y : IP_X);
            st_tag = "R10";
            set_pkt(k[0], (k % 7) != 3, MAC_A, (k % 11 == 5) ? MAC_C : MAC_B,
                    s, (k % 5 == 2) ? IP_Y : IP_G, 16'(30 + k * 3));
            cycle();
            if (k % 9 == 8) cycle();
        end

        // R2: drop the source MAC entry, then a packet must miss
        cfg(2'd0, 3'd0, 1'b0, MAC_A, 1'b0);
        pkt(1'b0, 1'b1, MAC_A, MAC_B, IP_Z, IP_X, 16'd64);

        repeat (4) cycle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule